// File: doc/BRIEF.md
# Cyclo-Static Actor Firing Controller

This block decides, cycle by cycle, when one hardware dataflow actor may run. It looks at the token count held by each input FIFO and at the free room in each output FIFO. It raises `fire` only when every input holds at least as many tokens as the actor takes from that port in its present phase, and every output can take what the actor writes in that phase. Each port's rate is a short vector of counts that repeats. Successive firings therefore take and deliver different amounts. A port whose vector has a single entry behaves as a plain fixed-rate port.

During a firing cycle the controller drives the per-port pop and push amounts for that phase. The FIFOs apply those amounts at the same clock edge. At that edge the controller steps its phase. The actor's phase count is the least common multiple of all the port vector lengths, and the phase wraps back to zero after the last phase.

The data paths are not part of this block. Back-pressure enters only through `out_space`: an output that lacks room for the current phase's production holds the firing off. An input whose current entry is zero never holds it off.

Top module: `cs_fire_ctrl`

## Requirements
- R1: `fire` is high in a cycle exactly when `rst` is low, every input's `in_count` is at least that port's entry for the current firing, and every output's `out_space` is at least that port's entry for the current firing.
- R2: When `fire` is high, `pop_cnt` and `push_cnt` carry each port's entry for the current firing. When `fire` is low, both are zero. Port p occupies bits [p*CW +: CW].
- R3: `phase` equals the number of firings since reset modulo the phase count, which is the least common multiple of all port vector lengths (6 with the default vectors). It changes only on a clock edge at which `fire` was high.
- R4: An input whose entry is zero for the current firing does not block firing, even with `in_count` zero. With the defaults, input 1 has vector {0,2,1}.
- R5: Firing k uses element k mod L of each port's vector, where L is that port's vector length. With the default output vectors {1,0} and {0,1}, firings push one token alternately to output 0 and output 1, starting with output 0.
- R6: `rst` is synchronous and active high. While it is high, `fire` is low. After a reset edge, `phase` is 0 and every port restarts at element 0.
- R7: `stalled` is high in every cycle in which `fire` is low, and low when `fire` is high.
- R8: A port whose vector has length one uses the same count on every firing. With the defaults, input 0 pops 1 on every firing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_count | input | N_IN*CW | Tokens held by each input FIFO |
| out_space | input | N_OUT*CW | Free slots in each output FIFO |
| fire | output | 1 | Actor fires this cycle |
| pop_cnt | output | N_IN*CW | Tokens to remove from each input FIFO on this firing |
| push_cnt | output | N_OUT*CW | Tokens to add to each output FIFO on this firing |
| phase | output | PW | Current phase of the actor |
| stalled | output | 1 | Firing is held off this cycle |

## Verification
The assertions assume that the FIFOs report counts that are current for the cycle being judged. They also assume that `in_count` and `out_space` settle before each clock edge, since the firing decision is combinational from them.

The bench changes these inputs only shortly after a rising edge and reads the outputs at the falling edge. It sweeps every count combination around the phase thresholds, from zero up to just past the largest entry. The phase walks through all six phases many times, so each phase meets every level of starvation and back-pressure.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int LEN_W = 4;

  function automatic int gcd_int(input int a, input int b);
    int x;
    int y;
    int t;
    x = a;
    y = b;
    while (y != 0) begin
      t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  function automatic int lcm_int(input int a, input int b);
    if (a == 0 || b == 0) return 1;
    return (a / gcd_int(a, b)) * b;
  endfunction
endpackage

// File: rtl/cs_rate_seq.sv
module cs_rate_seq #(
  parameter int MAX_LEN = 8,
  parameter int RW = 4,
  parameter int LEN = 1,
  parameter logic [MAX_LEN*RW-1:0] RATES = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [RW-1:0] rate
);
  localparam int IW = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  generate
    if (LEN <= 1) begin : g_fixed
      logic unused_fixed;
      assign unused_fixed = &{1'b0, clk, rst, adv};
      assign rate = RATES[RW-1:0];
    end else begin : g_cyclic
      logic [IW-1:0] idx;
      always_ff @(posedge clk) begin
        if (rst) idx <= '0;
        else if (adv) idx <= (idx == IW'(LEN - 1)) ? '0 : idx + 1'b1;
      end
      assign rate = RATES[int'(idx)*RW +: RW];
    end
  endgenerate
endmodule

// File: rtl/cs_port_gate.sv
module cs_port_gate #(
  parameter int RW = 4
) (
  input  logic [RW-1:0] level,
  input  logic [RW-1:0] need,
  output logic          ok
);
  assign ok = (level >= need);
endmodule

// File: rtl/cs_phase_ctr.sv
module cs_phase_ctr #(
  parameter int PHASES = 1,
  parameter int PW = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [PW-1:0] phase
);
  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else if (adv) phase <= (phase == PW'(PHASES - 1)) ? '0 : phase + 1'b1;
  end
endmodule

// File: rtl/cs_fire_ctrl.sv
module cs_fire_ctrl #(
  parameter int N_IN = 2,
  parameter int N_OUT = 2,
  parameter int MAX_LEN = 8,
  parameter int CW = 4,
  parameter logic [N_IN*cs_pkg::LEN_W-1:0]  IN_LENS   = 8'h31,
  parameter logic [N_IN*MAX_LEN*CW-1:0]     IN_RATES  = 64'h0000_0120_0000_0001,
  parameter logic [N_OUT*cs_pkg::LEN_W-1:0] OUT_LENS  = 8'h22,
  parameter logic [N_OUT*MAX_LEN*CW-1:0]    OUT_RATES = 64'h0000_0010_0000_0001,
  localparam int PHASES = calc_phases(),
  localparam int PW = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_IN*CW-1:0]  in_count,
  input  logic [N_OUT*CW-1:0] out_space,
  output logic                fire,
  output logic [N_IN*CW-1:0]  pop_cnt,
  output logic [N_OUT*CW-1:0] push_cnt,
  output logic [PW-1:0]       phase,
  output logic                stalled
);
  function automatic int calc_phases();
    int acc;
    acc = 1;
    for (int p = 0; p < N_IN; p++)
      acc = cs_pkg::lcm_int(acc, int'(IN_LENS[p*cs_pkg::LEN_W +: cs_pkg::LEN_W]));
    for (int p = 0; p < N_OUT; p++)
      acc = cs_pkg::lcm_int(acc, int'(OUT_LENS[p*cs_pkg::LEN_W +: cs_pkg::LEN_W]));
    return acc;
  endfunction

  localparam int SEG = MAX_LEN * CW;

  logic [N_IN-1:0]  in_ok;
  logic [N_OUT-1:0] out_ok;

  generate
    for (genvar p = 0; p < N_IN; p++) begin : g_in
      logic [CW-1:0] need;
      cs_rate_seq #(
        .MAX_LEN(MAX_LEN), .RW(CW),
        .LEN(int'(IN_LENS[p*cs_pkg::LEN_W +: cs_pkg::LEN_W])),
        .RATES(IN_RATES[p*SEG +: SEG])
      ) u_seq (.clk(clk), .rst(rst), .adv(fire), .rate(need));
      cs_port_gate #(.RW(CW)) u_gate (
        .level(in_count[p*CW +: CW]), .need(need), .ok(in_ok[p]));
      assign pop_cnt[p*CW +: CW] = fire ? need : '0;
    end
    for (genvar p = 0; p < N_OUT; p++) begin : g_out
      logic [CW-1:0] give;
      cs_rate_seq #(
        .MAX_LEN(MAX_LEN), .RW(CW),
        .LEN(int'(OUT_LENS[p*cs_pkg::LEN_W +: cs_pkg::LEN_W])),
        .RATES(OUT_RATES[p*SEG +: SEG])
      ) u_seq (.clk(clk), .rst(rst), .adv(fire), .rate(give));
      cs_port_gate #(.RW(CW)) u_gate (
        .level(out_space[p*CW +: CW]), .need(give), .ok(out_ok[p]));
      assign push_cnt[p*CW +: CW] = fire ? give : '0;
    end
  endgenerate

  assign fire    = !rst && (&in_ok) && (&out_ok);
  assign stalled = !fire;

  cs_phase_ctr #(.PHASES(PHASES), .PW(PW)) u_phase (
    .clk(clk), .rst(rst), .adv(fire), .phase(phase));
endmodule

// File: rtl/cs_fire_ctrl_chk.sv
module cs_fire_ctrl_chk #(
  parameter int N_IN = 2,
  parameter int N_OUT = 2,
  parameter int CW = 4,
  parameter int PHASES = 1,
  parameter int PW = 1
) (
  input logic                clk,
  input logic                rst,
  input logic [N_IN*CW-1:0]  in_count,
  input logic [N_OUT*CW-1:0] out_space,
  input logic                fire,
  input logic [N_IN*CW-1:0]  pop_cnt,
  input logic [N_OUT*CW-1:0] push_cnt,
  input logic [PW-1:0]       phase,
  input logic                stalled
);
  generate
    for (genvar p = 0; p < N_IN; p++) begin : g_in
      AST_IN_HAS_TOKENS: assert property (@(posedge clk) disable iff (rst)
        fire |-> in_count[p*CW +: CW] >= pop_cnt[p*CW +: CW]); // R1
    end
    for (genvar p = 0; p < N_OUT; p++) begin : g_out
      AST_OUT_HAS_ROOM: assert property (@(posedge clk) disable iff (rst)
        fire |-> out_space[p*CW +: CW] >= push_cnt[p*CW +: CW]); // R1
    end
  endgenerate

  AST_IDLE_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
    !fire |-> (pop_cnt == '0 && push_cnt == '0)); // R2
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(phase)); // R3
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    fire |=> phase == (($past(phase) == PW'(PHASES - 1)) ? '0 : $past(phase) + 1'b1)); // R3
  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(phase) < PHASES); // R3
  AST_QUIET_IN_RESET: assert property (@(posedge clk)
    rst |-> !fire); // R6
  AST_RESET_PHASE: assert property (@(posedge clk)
    $past(rst) |-> phase == '0); // R6
  AST_STALL_FLAG: assert property (@(posedge clk) disable iff (rst)
    $rose(stalled) |-> $past(fire)); // R7
endmodule

bind cs_fire_ctrl cs_fire_ctrl_chk #(
  .N_IN(N_IN), .N_OUT(N_OUT), .CW(CW), .PHASES(PHASES), .PW(PW)
) u_chk (
  .clk(clk), .rst(rst), .in_count(in_count), .out_space(out_space),
  .fire(fire), .pop_cnt(pop_cnt), .push_cnt(push_cnt),
  .phase(phase), .stalled(stalled)
);

// File: tb/cs_fire_ctrl_test.sv
`timescale 1ns/1ps
module cs_fire_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] in_count = '0;
  logic [7:0] out_space = '0;
  logic       fire;
  logic [7:0] pop_cnt;
  logic [7:0] push_cnt;
  logic [2:0] phase;
  logic       stalled;

  int vectors = 0;
  int errors = 0;
  int k = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cs_fire_ctrl uut (
    .clk(clk), .rst(rst), .in_count(in_count), .out_space(out_space),
    .fire(fire), .pop_cnt(pop_cnt), .push_cnt(push_cnt),
    .phase(phase), .stalled(stalled)
  );

  function automatic int need1(int f);
    case (f % 3)
      0: return 0;
      1: return 2;
      default: return 1;
    endcase
  endfunction
  function automatic int give0(int f); return (f % 2 == 0) ? 1 : 0; endfunction
  function automatic int give1(int f); return (f % 2 == 1) ? 1 : 0; endfunction

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (firing %0d)", tag, act, exp, k);
    end
  endtask

  task automatic apply(int c0, int c1, int s0, int s1);
    bit ef;
    @(posedge clk);
    #1;
    in_count  = {4'(c1), 4'(c0)};
    out_space = {4'(s1), 4'(s0)};
    @(negedge clk);
    ef = (c0 >= 1) && (c1 >= need1(k)) && (s0 >= give0(k)) && (s1 >= give1(k));
    if (need1(k) == 0 && c1 == 0) chk("R4 zero entry does not block", int'(fire), int'(ef));
    else chk("R1 fire decision", int'(fire), int'(ef));
    chk("R7 stalled", int'(stalled), int'(!ef));
    chk("R3 phase", int'(phase), k % 6);
    chk("R8 pop in0", int'(pop_cnt[3:0]), ef ? 1 : 0);
    chk("R2 pop in1", int'(pop_cnt[7:4]), ef ? need1(k) : 0);
    chk("R5 push out0", int'(push_cnt[3:0]), ef ? give0(k) : 0);
    chk("R5 push out1", int'(push_cnt[7:4]), ef ? give1(k) : 0);
    if (ef) k++;
  endtask

  initial begin
    in_count  = 8'hFF;
    out_space = 8'hFF;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R6 no fire in reset", int'(fire), 0);
    chk("R6 phase in reset", int'(phase), 0);
    chk("R7 stalled in reset", int'(stalled), 1);
    in_count  = '0;
    out_space = '0;
    rst = 1'b0;

    for (int r = 0; r < 12; r++)
      for (int c0 = 0; c0 < 3; c0++)
        for (int c1 = 0; c1 < 4; c1++)
          for (int s0 = 0; s0 < 2; s0++)
            for (int s1 = 0; s1 < 2; s1++)
              apply(c0, c1, s0, s1);

    for (int i = 0; i < 9; i++) apply(15, 15, 15, 15);

    @(posedge clk);
    #1;
    rst = 1'b1;
    @(negedge clk);
    chk("R6 no fire in reset", int'(fire), 0);
    @(posedge clk);
    #1;
    rst = 1'b0;
    in_count  = '0;
    out_space = '0;
    @(negedge clk);
    k = 0;
    chk("R6 phase after reset", int'(phase), 0);
    for (int i = 0; i < 7; i++) apply(15, 15, 15, 15);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vectors++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule